// File: doc/BRIEF.md
# Transfer activation enable controller

This block decides which interrupt requests start a data-transfer engine instead of reaching the CPU. It holds one enable bit per interrupt source, organised as a bank of byte-wide registers. Software sets and clears these bits through a small synchronous register port. Sources whose enable bit is clear pass straight through to the CPU. Among the enabled sources that are requesting, the block picks the lowest-numbered one and offers it to the transfer engine as a start request. The engine later signals that the unit transfer is finished.

The block models one active channel at a time. That channel has a 16-bit block counter, loaded through a configuration strobe. A loaded value of zero stands for 65536 transfers. Each finished transfer lowers the counter by one. The enable bit of the active source clears itself in hardware in either of two cases: the channel's interrupt-select mode bit was set when the start was accepted, or the counter has just reached zero. When the bit clears, a one-cycle end interrupt is raised with the source index, so the CPU can take over.

The start request is a valid/ready channel. Once `xfer_valid` is high, it stays high with `xfer_src` unchanged until the engine raises `xfer_ready`. The request does not change even if the pending inputs change meanwhile. The engine may hold `xfer_ready` low for any number of cycles. The done strobe is a plain control pin and is acted on only while a transfer is in progress.

Top module: `xfer_act_enable`

## Requirements
- R1: After reset, every enable bit is 0, `xfer_valid` and `end_irq` are low, and `end_src` and `xfer_src` read 0.
- R2: A write with `reg_wr` high and `reg_sel` = k (k in 0..6) loads enable bits 8k+7..8k from `reg_wdata` at the clock edge. `reg_rdata` shows those bits for the selected k combinationally. For `reg_sel` = 7, writes are ignored and reads return 0.
- R3: `cpu_irq_pass[i]` equals `irq_req[i]` AND NOT enable bit i, at all times.
- R4: While idle, if any `irq_req[i]` with its enable bit set is high at a clock edge, the lowest such i is offered: `xfer_valid` goes high with `xfer_src` = i after that edge. Other pending sources wait.
- R5: An offered request keeps `xfer_valid` high and `xfer_src` stable until a clock edge with `xfer_ready` high. After that edge the block is busy and `xfer_valid` is low. `xfer_done` has no effect unless the block is busy.
- R6: The mode bit is sampled from `cfg_mode` at the accepting edge. If it is 1, the first `xfer_done` edge while busy clears the active source's enable bit. In the cycle after that edge, `end_irq` is high for exactly one cycle with `end_src` set to the source.
- R7: Each `xfer_done` edge while busy decrements the counter by 1, modulo 65536. If the counter goes from 1 to 0, the enable bit clears and `end_irq` pulses whatever the mode bit is. If the mode bit is 0 and the counter does not reach 0, the bit stays set and no `end_irq` occurs.
- R8: A counter value of 0 means 65536 transfers: a done event with the counter at 0 and mode 0 leaves the enable bit set.
- R9: If a hardware clear and a register write to the same byte occur at the same edge, the cleared bit ends at 0 and the other bits of that byte take the written value.
- R10: `cfg_load` loads `cfg_count` into the counter only while the block is not busy. Changes to `cfg_load`, `cfg_count` or `cfg_mode` during a busy period do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..6 enable bytes) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Enable bits of the selected register |
| irq_req | input | 56 | Interrupt request per source |
| cpu_irq_pass | output | 56 | Requests of non-enabled sources, to the CPU |
| xfer_valid | output | 1 | Transfer start request valid |
| xfer_ready | input | 1 | Engine accepts the start request |
| xfer_src | output | 6 | Source index of the start request |
| xfer_done | input | 1 | Engine finished one unit transfer |
| cfg_load | input | 1 | Load strobe for the block counter |
| cfg_count | input | 16 | Block count to load (0 = 65536) |
| cfg_mode | input | 1 | Interrupt-select mode bit, sampled on accept |
| end_irq | output | 1 | One-cycle interrupt on auto-clear |
| end_src | output | 6 | Source index for the end interrupt |

## Verification
On every cycle, the assertions check four things:
- a held offer keeps a stable source while it waits for ready;
- a hardware clear always wins over a simultaneous write;
- the enable bank changes only on a write or a clear;
- an end interrupt only ever follows a done event while busy, and at most one bit is cleared at a time.

Some behaviour can only be shown by the bench scenarios, which compare all outputs against the reference model:
- the lowest-index arbitration order;
- the exact transfer on which the count runs out;
- the 65536 meaning of a zero count;
- that a configuration change while busy is ignored.

// File: rtl/aen_pkg.sv
package aen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_BUSY  = 2'd2
  } aen_state_e;
endpackage

// File: rtl/aen_enable_bank.sv
module aen_enable_bank #(
  parameter int NREG = 7,
  parameter int BW   = 8,
  parameter int SELW = 3,
  localparam int NSRC = NREG * BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [SELW-1:0] sel,
  input  logic [BW-1:0]   wdata,
  output logic [BW-1:0]   rdata,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] en
);
  logic [NSRC-1:0] en_q, en_nxt;

  always_comb begin
    en_nxt = en_q;
    for (int r = 0; r < NREG; r++) begin
      if (wr && sel == SELW'(r)) en_nxt[r*BW +: BW] = wdata;
    end
    en_nxt = en_nxt & ~clr_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_nxt;
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NREG; r++) begin
      if (sel == SELW'(r)) rdata = en_q[r*BW +: BW];
    end
  end

  assign en = en_q;

  // R9: a cleared bit is zero after the edge, whatever was written
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((en_q & $past(clr_vec)) == '0));

  // R2: without a write or a clear the bank holds
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && clr_vec == '0) |=> $stable(en_q));
endmodule

// File: rtl/aen_lowest_pick.sv
module aen_lowest_pick #(
  parameter int N  = 56,
  parameter int IW = 6
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign hit = |req;
endmodule

// File: rtl/aen_xfer_ctrl.sv
module aen_xfer_ctrl
  import aen_pkg::*;
#(
  parameter int NSRC = 56,
  parameter int IW   = 6,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [IW-1:0]   pick_idx,
  output logic            xfer_valid,
  input  logic            xfer_ready,
  output logic [IW-1:0]   xfer_src,
  input  logic            xfer_done,
  input  logic            cfg_load,
  input  logic [CNTW-1:0] cfg_count,
  input  logic            cfg_mode,
  output logic [NSRC-1:0] clr_vec,
  output logic            end_irq,
  output logic [IW-1:0]   end_src
);
  aen_state_e      state;
  logic [IW-1:0]   src_q;
  logic [CNTW-1:0] cnt_q;
  logic            mode_q;
  logic            end_irq_q;
  logic [IW-1:0]   end_src_q;
  logic            done_evt, last_unit, auto_clr;

  assign done_evt  = (state == ST_BUSY) && xfer_done;
  assign last_unit = (cnt_q == CNTW'(1));
  assign auto_clr  = done_evt && (mode_q || last_unit);
  assign clr_vec   = auto_clr ? (NSRC'(1) << src_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      src_q     <= '0;
      cnt_q     <= '0;
      mode_q    <= 1'b0;
      end_irq_q <= 1'b0;
      end_src_q <= '0;
    end else begin
      end_irq_q <= auto_clr;
      if (auto_clr) end_src_q <= src_q;
      if (done_evt) cnt_q <= cnt_q - CNTW'(1);
      else if (cfg_load && state != ST_BUSY) cnt_q <= cfg_count;
      case (state)
        ST_IDLE: if (hit) begin
          src_q <= pick_idx;
          state <= ST_OFFER;
        end
        ST_OFFER: if (xfer_ready) begin
          mode_q <= cfg_mode;
          state  <= ST_BUSY;
        end
        ST_BUSY: if (xfer_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign xfer_valid = (state == ST_OFFER);
  assign xfer_src   = src_q;
  assign end_irq    = end_irq_q;
  assign end_src    = end_src_q;

  // R5: an unaccepted offer stays up with the same source
  a_r5_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_src)));

  // R6: an end interrupt only follows a done event in the busy state
  a_r6_end_cause: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> ($past(xfer_done) && $past(state == ST_BUSY)));

  // R6: never more than one enable bit is cleared at a time
  a_r6_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));

  // R8: a zero counter under mode 0 never clears
  a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && cnt_q == '0 && !mode_q) |-> (clr_vec == '0));
endmodule

// File: rtl/xfer_act_enable.sv
module xfer_act_enable #(
  parameter int NREG = 7,
  parameter int BW   = 8,
  parameter int CNTW = 16,
  localparam int NSRC = NREG * BW,
  localparam int SELW = $clog2(NREG + 1),
  localparam int IW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [SELW-1:0] reg_sel,
  input  logic [BW-1:0]   reg_wdata,
  output logic [BW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] irq_req,
  output logic [NSRC-1:0] cpu_irq_pass,
  output logic            xfer_valid,
  input  logic            xfer_ready,
  output logic [IW-1:0]   xfer_src,
  input  logic            xfer_done,
  input  logic            cfg_load,
  input  logic [CNTW-1:0] cfg_count,
  input  logic            cfg_mode,
  output logic            end_irq,
  output logic [IW-1:0]   end_src
);
  logic [NSRC-1:0] en, clr_vec, pending;
  logic            hit;
  logic [IW-1:0]   pick_idx;

  aen_enable_bank #(.NREG(NREG), .BW(BW), .SELW(SELW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .clr_vec(clr_vec), .en(en)
  );

  assign pending      = irq_req & en;
  assign cpu_irq_pass = irq_req & ~en;

  aen_lowest_pick #(.N(NSRC), .IW(IW)) u_pick (
    .req(pending), .hit(hit), .idx(pick_idx)
  );

  aen_xfer_ctrl #(.NSRC(NSRC), .IW(IW), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hit(hit), .pick_idx(pick_idx),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_src(xfer_src),
    .xfer_done(xfer_done), .cfg_load(cfg_load), .cfg_count(cfg_count),
    .cfg_mode(cfg_mode), .clr_vec(clr_vec), .end_irq(end_irq), .end_src(end_src)
  );
endmodule

// File: tb/tb_xfer_act_enable.sv
`timescale 1ns/1ps
module tb_xfer_act_enable;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_sel = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [55:0] irq_req = 0;
  logic [55:0] cpu_irq_pass;
  logic        xfer_valid;
  logic        xfer_ready = 0;
  logic [5:0]  xfer_src;
  logic        xfer_done = 0;
  logic        cfg_load = 0;
  logic [15:0] cfg_count = 0;
  logic        cfg_mode = 0;
  logic        end_irq;
  logic [5:0]  end_src;

  always #10 clk = ~clk;

  xfer_act_enable dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .cpu_irq_pass(cpu_irq_pass), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_src(xfer_src), .xfer_done(xfer_done), .cfg_load(cfg_load),
    .cfg_count(cfg_count), .cfg_mode(cfg_mode), .end_irq(end_irq), .end_src(end_src)
  );

  int    n_checks = 0;
  int    n_fails = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [55:0] m_en = 0;
  int          m_state = 0;
  int          m_src = 0;
  int          m_cnt = 0;
  bit          m_mode = 0;
  bit          m_end = 0;
  int          m_end_src = 0;

  always @(posedge clk) begin
    logic [55:0] nen, pend;
    bit last;
    if (!rst_n) begin
      m_en = 0; m_state = 0; m_src = 0; m_cnt = 0;
      m_mode = 0; m_end = 0; m_end_src = 0;
    end else begin
      nen = m_en;
      if (reg_wr && reg_sel < 7) nen[reg_sel*8 +: 8] = reg_wdata;
      m_end = 0;
      case (m_state)
        0: begin
          pend = irq_req & m_en;
          if (pend != 0) begin
            for (int i = 55; i >= 0; i--) if (pend[i]) m_src = i;
            m_state = 1;
          end
          if (cfg_load) m_cnt = cfg_count;
        end
        1: begin
          if (cfg_load) m_cnt = cfg_count;
          if (xfer_ready) begin m_mode = cfg_mode; m_state = 2; end
        end
        default: if (xfer_done) begin
          last = (m_cnt == 1);
          m_cnt = (m_cnt + 65535) % 65536;
          if (m_mode || last) begin
            nen[m_src] = 0; m_end = 1; m_end_src = m_src;
          end
          m_state = 0;
        end
      endcase
      m_en = nen;
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk); #5;
    if (rst_n) begin
      chk("xfer_valid", 64'(xfer_valid), 64'(m_state == 1));
      chk("xfer_src", 64'(xfer_src), 64'(m_src));
      chk("end_irq", 64'(end_irq), 64'(m_end));
      chk("end_src", 64'(end_src), 64'(m_end_src));
      chk("reg_rdata", 64'(reg_rdata), (reg_sel < 7) ? 64'(m_en[reg_sel*8 +: 8]) : 64'd0);
      chk("cpu_irq_pass", 64'(cpu_irq_pass), 64'(irq_req & ~m_en));
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(int sel, logic [7:0] d);
    reg_wr = 1; reg_sel = 3'(sel); reg_wdata = d;
    cyc(1);
    reg_wr = 0;
  endtask

  task automatic load(logic [15:0] c, bit mode);
    cfg_load = 1; cfg_count = c; cfg_mode = mode;
    cyc(1);
    cfg_load = 0;
  endtask

  // engine responder; optional write at done, optional config poke while busy
  task automatic serve(int rdy_wait, int done_wait, bit wr_done, int wsel, logic [7:0] wd, bit poke);
    bit keep_mode;
    xfer_ready = 0;
    while (!xfer_valid) cyc(1);
    cyc(rdy_wait);
    xfer_ready = 1;
    cyc(1);
    xfer_ready = 0;
    keep_mode = cfg_mode;
    if (poke) begin cfg_load = 1; cfg_count = 16'd1; cfg_mode = ~keep_mode; end
    cyc(done_wait);
    xfer_done = 1;
    if (wr_done) begin reg_wr = 1; reg_sel = 3'(wsel); reg_wdata = wd; end
    cyc(1);
    xfer_done = 0; reg_wr = 0; cfg_load = 0; cfg_mode = keep_mode;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cur_req = "R1";
    for (int s = 0; s < 8; s++) begin reg_sel = 3'(s); cyc(1); end

    cur_req = "R2";
    for (int s = 0; s < 7; s++) wreg(s, 8'(8'h3C ^ (s * 37)));
    for (int s = 0; s < 8; s++) begin reg_sel = 3'(s); cyc(1); end
    wreg(7, 8'hFF);
    reg_sel = 7; cyc(1);
    for (int s = 0; s < 7; s++) wreg(s, 8'h00);

    cur_req = "R3";
    irq_req = 56'h00A5_0000_F00F_0001;
    cyc(3);
    wreg(1, 8'hF0);
    cyc(2);
    irq_req = 0; wreg(1, 8'h00);

    cur_req = "R4";
    load(16'd100, 0);
    wreg(0, 8'h20); wreg(1, 8'h10); wreg(5, 8'h01);
    irq_req[40] = 1; irq_req[12] = 1; irq_req[5] = 1;
    serve(0, 1, 0, 0, 0, 0); irq_req[5] = 0;
    serve(0, 1, 0, 0, 0, 0); irq_req[12] = 0;
    serve(0, 1, 0, 0, 0, 0); irq_req[40] = 0;
    cyc(2);

    cur_req = "R5";
    xfer_done = 1; cyc(1); xfer_done = 0;
    irq_req[12] = 1;
    serve(4, 3, 0, 0, 0, 0);
    irq_req[12] = 0; cyc(2);

    cur_req = "R6";
    wreg(2, 8'h10); cfg_mode = 1;
    irq_req[20] = 1;
    serve(1, 2, 0, 0, 0, 0);
    irq_req[20] = 0; cfg_mode = 0; cyc(2);

    cur_req = "R7";
    load(16'd3, 0);
    wreg(4, 8'h02); irq_req[33] = 1;
    for (int k = 0; k < 3; k++) serve(0, 1, 0, 0, 0, 0);
    irq_req[33] = 0; cyc(2);

    cur_req = "R8";
    load(16'd0, 0);
    wreg(0, 8'h04); irq_req[2] = 1;
    serve(0, 1, 0, 0, 0, 0);
    irq_req[2] = 0; cyc(1);
    reg_sel = 0; cyc(1);
    load(16'd1, 0); irq_req[2] = 1;
    serve(0, 1, 0, 0, 0, 0);
    irq_req[2] = 0; cyc(2);

    cur_req = "R9";
    wreg(1, 8'hFF); cfg_mode = 1; irq_req[9] = 1;
    serve(0, 1, 1, 1, 8'h0E, 0);
    irq_req[9] = 0; cfg_mode = 0;
    reg_sel = 1; cyc(2);

    cur_req = "R10";
    wreg(6, 8'h80); load(16'd2, 0); irq_req[55] = 1;
    serve(0, 2, 0, 0, 0, 1);
    reg_sel = 6; cyc(1);
    serve(0, 1, 0, 0, 0, 0);
    irq_req[55] = 0; cyc(3);

    report();
  end
endmodule